// File: doc/BRIEF.md
# Striped Test-Pattern Video Generator

This block produces a synthetic raster with standard monitor timing, so that a display path can be brought up and checked without any image source. It counts pixel clocks and lines, drives active-low horizontal and vertical sync, a blanking flag, and a 24-bit colour. Inside a programmable rectangle it paints one of three patterns: horizontal bands, vertical bands, or a checkerboard. Band and cell size is a power of two. The colour begins at a base value and moves by a per-band step. Each 8-bit channel wraps modulo 256.

Settings are written through a small Wishbone slave port into a staging copy. A commit flag guards that copy. The generator copies the staged settings into its working set only at the clock where the raster wraps from the last position to the first pixel of a new frame, and only when the flag is set. A frame never mixes two sets of settings. Resolution, porches and sync widths are parameters. The defaults give 1024x768 with 1344 clocks per line and 806 lines per frame, for a 65 MHz pixel clock.

Top module: `stripe_video_gen`

## Requirements
- R1: While reset is held, and after it until the first visible pixel reaches the outputs, the block drives vid_blank_o=1, vid_hs_n_o=1, vid_vs_n_o=1 and vid_rgb_o=0. The working settings start all zero, with pattern off.
- R2: A line lasts H_ACT+H_FP+H_SYNC+H_BP clocks. vid_hs_n_o is low for exactly H_SYNC clocks, starting at column H_ACT+H_FP of each line.
- R3: A frame lasts V_ACT+V_FP+V_SYNC+V_BP lines. vid_vs_n_o is low for the whole of lines V_ACT+V_FP up to V_ACT+V_FP+V_SYNC-1.
- R4: vid_blank_o is high exactly outside columns 0..H_ACT-1 of lines 0..V_ACT-1. vid_rgb_o is zero in three cases: while blanked, outside the inclusive rectangle x0..x1, y0..y1, and when the pattern is off.
- R5: Pattern 1 (horizontal bands) uses the band index n = (y-y0)>>w. Channel k, bits 8k+7..8k (red in 23:16), equals base_k + n*step_k modulo 256.
- R6: Pattern 2 (vertical bands) uses n = (x-x0)>>w and the same colour rule as R5.
- R7: Pattern 3 (checkerboard) uses cx=(x-x0)>>w and cy=(y-y0)>>w. A cell is painted only when bit 0 of cx XOR bit 0 of cy is 1, with n = cx+cy. Every other cell shows zero.
- R8: Register map (word address on wb_adr_i): 0 control (bits 1:0 pattern 0 off, 1 horizontal, 2 vertical, 3 checker; bit 8 commit), 1 x0, 2 y0, 3 x1, 4 y1 (bits 11:0 each), 5 width shift w (bits 3:0), 6 base colour (23:0), 7 colour step (23:0). Each strobe is acknowledged one clock later for exactly one clock. A read returns the staged value on the acknowledge clock, and address 0 reads back the commit flag in bit 8.
- R9: A write to addresses 1..7 clears the commit flag. A write to address 0 sets the flag to data bit 8.
- R10: The working settings change only at the wrap into a new frame, and only when the commit flag is set. A frame that is already running keeps its settings whatever is written.
- R11: The first pixel of a frame, which appears on the outputs one clock after the raster wraps, already uses the settings copied at that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Register word address |
| wb_dat_i | input | 32 | Write data |
| wb_ack_o | output | 1 | Acknowledge |
| wb_dat_o | output | 32 | Read data |
| vid_rgb_o | output | 24 | Pixel colour, red in 23:16 |
| vid_hs_n_o | output | 1 | Horizontal sync, active low |
| vid_vs_n_o | output | 1 | Vertical sync, active low |
| vid_blank_o | output | 1 | High outside the visible area |

## Verification
Every video output passes through one register, so the value for raster position p appears one clock after the counters reach p. The bench locks onto the first unblanked sample as position (0,0) and from there advances its own position by one per clock. Its own copy of the working settings switches when the sample for the last position is taken, so the check of the next sample, pixel (0,0), already expects the new settings. A bus acknowledge and its read data are due on the clock after the strobe is seen, and the bench samples them half a clock after that edge. Register writes are issued only in the middle of a frame, well away from the wrap.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  localparam int COORD_W = 12;
  localparam int CH_W    = 8;
  localparam int RGB_W   = 24;
  localparam int NCH     = RGB_W / CH_W;
  localparam int SH_W    = 4;

  typedef enum logic [1:0] {
    PAT_OFF   = 2'd0,
    PAT_ROWS  = 2'd1,
    PAT_COLS  = 2'd2,
    PAT_CHECK = 2'd3
  } pat_mode_e;

  typedef struct packed {
    pat_mode_e          mode;
    logic [COORD_W-1:0] x0;
    logic [COORD_W-1:0] y0;
    logic [COORD_W-1:0] x1;
    logic [COORD_W-1:0] y1;
    logic [SH_W-1:0]    wsh;
    logic [RGB_W-1:0]   base;
    logic [RGB_W-1:0]   step;
  } pat_cfg_t;
endpackage

// File: rtl/vpg_timing.sv
module vpg_timing #(
  parameter int H_ACT  = 1024,
  parameter int H_FP   = 24,
  parameter int H_SYNC = 136,
  parameter int H_BP   = 160,
  parameter int V_ACT  = 768,
  parameter int V_FP   = 3,
  parameter int V_SYNC = 6,
  parameter int V_BP   = 29,
  parameter int XW     = 11,
  parameter int YW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [XW-1:0] hpos,
  output logic [YW-1:0] vpos,
  output logic          active,
  output logic          hsync,
  output logic          vsync,
  output logic          frame_req
);
  localparam int H_TOT  = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT  = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HS_BEG = H_ACT + H_FP;
  localparam int HS_END = HS_BEG + H_SYNC;
  localparam int VS_BEG = V_ACT + V_FP;
  localparam int VS_END = VS_BEG + V_SYNC;

  logic          h_last, v_last;
  logic [XW-1:0] h_nxt;
  logic [YW-1:0] v_nxt;

  always_comb begin
    h_last = (int'(hpos) == H_TOT - 1);
    v_last = (int'(vpos) == V_TOT - 1);
    h_nxt  = h_last ? '0 : hpos + XW'(1);
    v_nxt  = vpos;
    if (h_last) v_nxt = v_last ? '0 : vpos + YW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos <= '0;
      vpos <= '0;
    end else begin
      hpos <= h_nxt;
      vpos <= v_nxt;
    end
  end

  assign active    = (int'(hpos) < H_ACT) && (int'(vpos) < V_ACT);
  assign hsync     = (int'(hpos) >= HS_BEG) && (int'(hpos) < HS_END);
  assign vsync     = (int'(vpos) >= VS_BEG) && (int'(vpos) < VS_END);
  assign frame_req = h_last && v_last;

  // a line ends by returning to column zero
  p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(hpos) == H_TOT - 1) |=> (hpos == '0));

  // the line counter moves only after the last column of a line
  p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vpos) |-> (int'($past(hpos)) == H_TOT - 1));
endmodule

// File: rtl/vpg_regs.sv
module vpg_regs
  import vpg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic [2:0]  wb_adr_i,
  input  logic [31:0] wb_dat_i,
  output logic        wb_ack_o,
  output logic [31:0] wb_dat_o,
  input  logic        frame_req,
  output pat_cfg_t    cfg_act
);
  pat_cfg_t    stage_q, stage_d;
  logic        valid_q, valid_d;
  logic        ack_q, ack_d;
  logic [31:0] rdat_q, rdat_d;
  logic        wr_en, rd_en, act_en;
  logic        unused_hi;

  assign unused_hi = ^wb_dat_i[31:RGB_W];

  always_comb begin
    ack_d   = wb_cyc_i && wb_stb_i && !ack_q;
    wr_en   = ack_d && wb_we_i;
    rd_en   = ack_d && !wb_we_i;
    act_en  = frame_req && valid_q;
    stage_d = stage_q;
    valid_d = valid_q;
    case (wb_adr_i)
      3'd0: begin
        stage_d.mode = pat_mode_e'(wb_dat_i[1:0]);
        valid_d      = wb_dat_i[8];
      end
      3'd1: begin stage_d.x0   = wb_dat_i[COORD_W-1:0]; valid_d = 1'b0; end
      3'd2: begin stage_d.y0   = wb_dat_i[COORD_W-1:0]; valid_d = 1'b0; end
      3'd3: begin stage_d.x1   = wb_dat_i[COORD_W-1:0]; valid_d = 1'b0; end
      3'd4: begin stage_d.y1   = wb_dat_i[COORD_W-1:0]; valid_d = 1'b0; end
      3'd5: begin stage_d.wsh  = wb_dat_i[SH_W-1:0];    valid_d = 1'b0; end
      3'd6: begin stage_d.base = wb_dat_i[RGB_W-1:0];   valid_d = 1'b0; end
      default: begin stage_d.step = wb_dat_i[RGB_W-1:0]; valid_d = 1'b0; end
    endcase
    case (wb_adr_i)
      3'd0:    rdat_d = {23'd0, valid_q, 6'd0, stage_q.mode};
      3'd1:    rdat_d = 32'(stage_q.x0);
      3'd2:    rdat_d = 32'(stage_q.y0);
      3'd3:    rdat_d = 32'(stage_q.x1);
      3'd4:    rdat_d = 32'(stage_q.y1);
      3'd5:    rdat_d = 32'(stage_q.wsh);
      3'd6:    rdat_d = 32'(stage_q.base);
      default: rdat_d = 32'(stage_q.step);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      valid_q <= 1'b0;
      ack_q   <= 1'b0;
      rdat_q  <= '0;
      cfg_act <= '0;
    end else begin
      ack_q <= ack_d;
      if (wr_en) begin
        stage_q <= stage_d;
        valid_q <= valid_d;
      end
      if (rd_en)  rdat_q  <= rdat_d;
      if (act_en) cfg_act <= stage_q;
    end
  end

  assign wb_ack_o = ack_q;
  assign wb_dat_o = rdat_q;

  p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack_o |=> !wb_ack_o);

  p_addr_write_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wb_adr_i != 3'd0)) |=> !valid_q);

  p_swap_at_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_act) |-> ($past(frame_req) && $past(valid_q)));
endmodule

// File: rtl/vpg_pixel.sv
module vpg_pixel
  import vpg_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 10
) (
  input  logic [XW-1:0]    hpos,
  input  logic [YW-1:0]    vpos,
  input  pat_cfg_t         cfg,
  output logic [RGB_W-1:0] pix_rgb
);
  logic [COORD_W-1:0] hx, vy, dx, dy;
  logic [CH_W-1:0]    cx, cy, n8;
  logic               in_roi, lit;

  always_comb begin
    hx     = COORD_W'(hpos);
    vy     = COORD_W'(vpos);
    in_roi = (hx >= cfg.x0) && (hx <= cfg.x1) && (vy >= cfg.y0) && (vy <= cfg.y1);
    dx     = hx - cfg.x0;
    dy     = vy - cfg.y0;
    cx     = CH_W'(dx >> cfg.wsh);
    cy     = CH_W'(dy >> cfg.wsh);
    case (cfg.mode)
      PAT_ROWS: begin n8 = cy;      lit = in_roi; end
      PAT_COLS: begin n8 = cx;      lit = in_roi; end
      PAT_CHECK: begin n8 = cx + cy; lit = in_roi && (cx[0] ^ cy[0]); end
      default:  begin n8 = '0;      lit = 1'b0; end
    endcase
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [2*CH_W-1:0] prod;
    assign prod = cfg.step[k*CH_W +: CH_W] * n8;
    assign pix_rgb[k*CH_W +: CH_W] = lit ? (cfg.base[k*CH_W +: CH_W] + prod[CH_W-1:0]) : '0;
  end
endmodule

// File: rtl/stripe_video_gen.sv
module stripe_video_gen
  import vpg_pkg::*;
#(
  parameter int H_ACT  = 1024,
  parameter int H_FP   = 24,
  parameter int H_SYNC = 136,
  parameter int H_BP   = 160,
  parameter int V_ACT  = 768,
  parameter int V_FP   = 3,
  parameter int V_SYNC = 6,
  parameter int V_BP   = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [2:0]       wb_adr_i,
  input  logic [31:0]      wb_dat_i,
  output logic             wb_ack_o,
  output logic [31:0]      wb_dat_o,
  output logic [RGB_W-1:0] vid_rgb_o,
  output logic             vid_hs_n_o,
  output logic             vid_vs_n_o,
  output logic             vid_blank_o
);
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int XW    = $clog2(H_TOT);
  localparam int YW    = $clog2(V_TOT);

  logic [1:0]       rst_sync;
  logic             rst_i;
  logic [XW-1:0]    hpos;
  logic [YW-1:0]    vpos;
  logic             active, hsync, vsync, frame_req;
  pat_cfg_t         cfg_act;
  logic [RGB_W-1:0] pix_rgb, rgb_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  vpg_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .XW(XW), .YW(YW)
  ) timing_i (
    .clk(clk), .rst_n(rst_i), .hpos(hpos), .vpos(vpos),
    .active(active), .hsync(hsync), .vsync(vsync), .frame_req(frame_req)
  );

  vpg_regs regs_i (
    .clk(clk), .rst_n(rst_i),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
    .wb_ack_o(wb_ack_o), .wb_dat_o(wb_dat_o),
    .frame_req(frame_req), .cfg_act(cfg_act)
  );

  vpg_pixel #(.XW(XW), .YW(YW)) pixel_i (
    .hpos(hpos), .vpos(vpos), .cfg(cfg_act), .pix_rgb(pix_rgb)
  );

  assign rgb_d = active ? pix_rgb : '0;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      vid_rgb_o   <= '0;
      vid_hs_n_o  <= 1'b1;
      vid_vs_n_o  <= 1'b1;
      vid_blank_o <= 1'b1;
    end else begin
      vid_rgb_o   <= rgb_d;
      vid_hs_n_o  <= !hsync;
      vid_vs_n_o  <= !vsync;
      vid_blank_o <= !active;
    end
  end

  p_dark_when_blank_r4: assert property (@(posedge clk) disable iff (!rst_i)
    vid_blank_o |-> (vid_rgb_o == '0));
endmodule

// File: tb/stripe_video_gen_tb_top.sv
module stripe_video_gen_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HA = 16, HF = 2, HS = 3, HB = 3;
  localparam int VA = 8,  VF = 1, VS = 2, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;

  typedef struct packed {
    logic [1:0]  mode;
    logic [11:0] x0;
    logic [11:0] y0;
    logic [11:0] x1;
    logic [11:0] y1;
    logic [3:0]  sh;
    logic [23:0] base;
    logic [23:0] step;
  } tcfg_t;

  localparam int NV = 7;
  localparam tcfg_t VECS [NV] = '{
    {2'd1, 12'd0, 12'd0, 12'd15, 12'd7, 4'd1, 24'h102030, 24'h010203},
    {2'd2, 12'd2, 12'd1, 12'd13, 12'd6, 4'd2, 24'hFF0080, 24'h10F001},
    {2'd3, 12'd0, 12'd0, 12'd15, 12'd7, 4'd2, 24'h000000, 24'h404040},
    {2'd3, 12'd3, 12'd2, 12'd10, 12'd5, 4'd0, 24'h112233, 24'hFF0180},
    {2'd1, 12'd7, 12'd4, 12'd7,  12'd4, 4'd0, 24'hA5A5A5, 24'h111111},
    {2'd0, 12'd0, 12'd0, 12'd15, 12'd7, 4'd0, 24'hFFFFFF, 24'h010101},
    {2'd2, 12'd5, 12'd0, 12'd20, 12'd7, 4'd1, 24'h0000F0, 24'h000011}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc, stb, we;
  logic [2:0]  adr;
  logic [31:0] wdat;
  logic        wb_ack;
  logic [31:0] wb_rdat;
  logic [23:0] vid_rgb;
  logic        vid_hs_n, vid_vs_n, vid_blank;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  bit    synced = 1'b0;
  int    px = 0, py = 0;
  tcfg_t m_stage, m_act;
  bit    m_valid;

  always #2.5 clk = ~clk;

  stripe_video_gen #(
    .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(wdat),
    .wb_ack_o(wb_ack), .wb_dat_o(wb_rdat),
    .vid_rgb_o(vid_rgb), .vid_hs_n_o(vid_hs_n), .vid_vs_n_o(vid_vs_n), .vid_blank_o(vid_blank)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      if (n_bad < 25) $display("FAIL %s act=%h exp=%h (x=%0d y=%0d)", tag, act, exp, px, py);
    end
  endtask

  function automatic logic [23:0] f_rgb(input int x, input int y, input tcfg_t c);
    int nx, ny, n;
    logic [23:0] r;
    if (x >= HA || y >= VA || c.mode == 2'd0) return 24'h0;
    if (x < int'(c.x0) || x > int'(c.x1) || y < int'(c.y0) || y > int'(c.y1)) return 24'h0;
    nx = (x - int'(c.x0)) >> c.sh;
    ny = (y - int'(c.y0)) >> c.sh;
    if (c.mode == 2'd1) n = ny;
    else if (c.mode == 2'd2) n = nx;
    else begin
      if (((nx ^ ny) & 1) == 0) return 24'h0;
      n = nx + ny;
    end
    for (int k = 0; k < 3; k++)
      r[8*k +: 8] = 8'((int'(c.base[8*k +: 8]) + int'(c.step[8*k +: 8]) * n) & 255);
    return r;
  endfunction

  function automatic string rgb_tag(input int x, input int y, input tcfg_t c);
    if (x >= HA || y >= VA || c.mode == 2'd0) return "R4";
    if (c.mode == 2'd1) return "R5";
    if (c.mode == 2'd2) return "R6";
    return "R7";
  endfunction

  // raster monitor: position model and expected outputs
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (!synced) begin
        if (vid_blank === 1'b0) synced = 1'b1;
        else begin
          // R1: idle outputs until first visible pixel
          chk(vid_hs_n === 1'b1 && vid_vs_n === 1'b1 && vid_rgb === 24'h0, "R1 idle after reset",
              {6'd0, vid_rgb, vid_hs_n, vid_vs_n}, {6'd0, 24'h0, 2'b11});
        end
      end
      if (synced) begin
        logic exp_hs, exp_vs, exp_bl;
        logic [23:0] exp_rgb;
        exp_hs  = !(px >= HA + HF && px < HA + HF + HS);
        exp_vs  = !(py >= VA + VF && py < VA + VF + VS);
        exp_bl  = !(px < HA && py < VA);
        exp_rgb = f_rgb(px, py, m_act);
        if (vid_hs_n !== exp_hs)
          chk(1'b0, "R2 hsync", 32'(vid_hs_n), 32'(exp_hs));
        else if (vid_vs_n !== exp_vs)
          chk(1'b0, "R3 vsync", 32'(vid_vs_n), 32'(exp_vs));
        else if (vid_blank !== exp_bl)
          chk(1'b0, "R4 blank", 32'(vid_blank), 32'(exp_bl));
        else if (vid_rgb !== exp_rgb)
          chk(1'b0, {rgb_tag(px, py, m_act), " colour (R10/R11 frame settings)"}, 32'(vid_rgb), 32'(exp_rgb));
        else
          chk(1'b1, "pixel", 32'(vid_rgb), 32'(exp_rgb));
        px++;
        if (px == HT) begin
          px = 0;
          py++;
          if (py == VT) py = 0;
        end
        if (px == 0 && py == 0 && m_valid) m_act = m_stage;
      end
    end
  end

  task automatic wb_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = a; wdat = d;
    @(negedge clk);
    chk(wb_ack === 1'b1, "R8 write ack due", 32'(wb_ack), 32'd1);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    case (a)
      3'd0: begin m_stage.mode = d[1:0]; m_valid = d[8]; end
      3'd1: begin m_stage.x0 = d[11:0]; m_valid = 1'b0; end
      3'd2: begin m_stage.y0 = d[11:0]; m_valid = 1'b0; end
      3'd3: begin m_stage.x1 = d[11:0]; m_valid = 1'b0; end
      3'd4: begin m_stage.y1 = d[11:0]; m_valid = 1'b0; end
      3'd5: begin m_stage.sh = d[3:0];  m_valid = 1'b0; end
      3'd6: begin m_stage.base = d[23:0]; m_valid = 1'b0; end
      default: begin m_stage.step = d[23:0]; m_valid = 1'b0; end
    endcase
    @(negedge clk);
    chk(wb_ack === 1'b0, "R8 ack one clock only", 32'(wb_ack), 32'd0);
  endtask

  task automatic wb_read(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a;
    @(negedge clk);
    chk(wb_ack === 1'b1 && wb_rdat === exp, tag, wb_rdat, exp);
    cyc = 1'b0; stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_line(input int k);
    do @(negedge clk); while (!(synced && py == k && px == 1));
  endtask

  task automatic program_cfg(input tcfg_t c);
    wb_write(3'd1, 32'(c.x0));
    wb_write(3'd2, 32'(c.y0));
    wb_write(3'd3, 32'(c.x1));
    wb_write(3'd4, 32'(c.y1));
    wb_write(3'd5, 32'(c.sh));
    wb_write(3'd6, 32'(c.base));
    wb_write(3'd7, 32'(c.step));
    wb_write(3'd0, 32'h100 | 32'(c.mode));
  endtask

  initial begin
    rst_n = 1'b0; cyc = 1'b0; stb = 1'b0; we = 1'b0; adr = '0; wdat = '0;
    m_stage = '0; m_act = '0; m_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(vid_blank === 1'b1 && vid_hs_n === 1'b1 && vid_vs_n === 1'b1 && vid_rgb === 24'h0,
          "R1 reset state", {4'd0, vid_rgb, vid_blank, vid_hs_n, vid_vs_n, 1'b0},
          {4'd0, 24'h0, 3'b111, 1'b0});
    end
    @(negedge clk);
    rst_n = 1'b1;
    wait_line(2);
    wb_read(3'd0, 32'h0, "R1 default control reads zero");

    // table of pattern settings, each shown for one whole frame
    for (int v = 0; v < NV; v++) begin
      program_cfg(VECS[v]);
      wait_line(2);
    end

    // R9/R10: staged change without commit must not reach the screen
    wb_write(3'd6, 32'h00ABCDEF);
    wb_read(3'd0, {23'd0, 1'b0, 6'd0, VECS[NV-1].mode}, "R9 commit cleared by data write");
    wb_read(3'd6, 32'h00ABCDEF, "R8 staged base read back");
    wait_line(2);
    wait_line(2);
    wb_write(3'd0, 32'h0000_0003);
    wb_read(3'd0, 32'h0000_0003, "R9 control write with bit 8 clear");
    wait_line(2);
    // R11: commit now, next frame's first pixel uses the new settings
    wb_write(3'd0, 32'h0000_0103);
    wb_read(3'd0, 32'h0000_0103, "R9 commit set by control write");
    wait_line(2);
    wait_line(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1..R11 act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule